// File: doc/BRIEF.md
# Block-Instruction Flag Generator

This block produces the status byte, the decremented counter and the loop decision for one step of an 8-bit processor's block instructions. These are the memory-to-memory copy, the memory compare and the port input/output string instructions, in their incrementing and decrementing forms and their self-repeating forms. The sequencer gives it the opcode class, the accumulator, the byte that was moved, compared, read or written, the BC pair as it was before the step, the L register after the pointer update, and the previous flags. One cycle after a valid strobe, it returns the new flags, the new BC, a request to repeat the opcode, and the cost of the step in NOP time units (4 T-states each).

The block reproduces the bits that real silicon produces but that are often left undefined: flag bits 5 and 3, and the half-carry, carry and parity rules of the I/O group. Memory and port accesses, pointer arithmetic and interrupts stay in the sequencer.

The control is a two-state machine. `ST_WAIT` holds while no strobe is present. A strobe in any state moves the machine to `ST_EMIT` and captures the result at the same clock edge. `ST_EMIT` returns to `ST_WAIT` when no new strobe arrives and stays in `ST_EMIT` when one does. `valid_out` is high only in `ST_EMIT`.

Top module: `blkop_flag_unit`

## Requirements
- R1: The `op` field is laid out as follows. Bit 3 is the repeat bit. Bits 2:1 select the group: 00 copy, 01 compare, 10 port input, 11 port output. Bit 0 selects the decrementing form. The flag byte is laid out as S=7, Z=6, F5=5, H=4, F3=3, PV=2, N=1, C=0.
- R2: A `valid_in` pulse that is sampled at a clock edge makes `valid_out` high for the cycle after that edge. The outputs are held until the next strobe. After reset, `valid_out` and all result outputs are 0.
- R3: Copy group. BC is decremented by one. PV is 1 when the new BC is non-zero. H and N are 0. S, Z and C keep their old values. With n = (acc + data) mod 256, F5 takes n bit 1 and F3 takes n bit 3.
- R4: Compare group. BC is decremented by one. N is 1. Z is 1 when acc equals data. S is bit 7 of (acc - data). H is 1 when acc[3:0] < data[3:0]. PV is 1 when the new BC is non-zero. C keeps its old value. With m = acc - data - H, F5 takes m bit 1 and F3 takes m bit 3.
- R5: I/O groups. Only B (BC[15:8]) is decremented, and C (BC[7:0]) is passed through unchanged. S and Z are taken from the new B, and F5 and F3 come from bits 5 and 3 of the new B. N is bit 7 of `data`.
- R6: The I/O sum k is a 9-bit value. For input it is data + ((C+1) mod 256) in the incrementing form and data + ((C-1) mod 256) in the decrementing form. For output it is data + `l_reg`, where `l_reg` already holds the updated L. H and C are both set to k bit 8. PV is even parity of (k[2:0] xor new B), so it is 1 when the number of 1 bits is even.
- R7: `repeat_req` is 1 only for a repeating opcode whose loop is still running. For copy, the new BC must be non-zero. For compare, the new BC must be non-zero and the bytes must differ. For I/O, the new B must be non-zero.
- R8: `nops` is 6 when `repeat_req` is 1. Otherwise it is the cost of the final or single step: 5 for copy, 4 for compare and 5 for I/O.
- R9: BC wraps around. A copy step from BC=0000h gives FFFFh with PV=1, and an I/O step from B=00h gives B=FFh with S=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| valid_in | input | 1 | Strobe: the inputs below hold a step |
| op | input | 4 | Opcode class {repeat, group[1:0], decrement} |
| acc | input | 8 | Accumulator |
| data | input | 8 | Byte moved, compared, read or written |
| bc_in | input | 16 | BC before the step |
| l_reg | input | 8 | L register after the pointer update |
| flags_in | input | 8 | Flags before the step |
| valid_out | output | 1 | Result valid for one cycle |
| flags_out | output | 8 | New flag byte |
| bc_out | output | 16 | BC after the step |
| repeat_req | output | 1 | Fetch the same opcode again |
| nops | output | 3 | Step cost in NOP units |

## Verification
The bench uses the default costs of 6, 5, 4 and 5 NOPs, which fit the 3-bit `nops` field. It covers all sixteen opcode classes through the vector table. The directed cases target the edges of the loop decision: a counter of exactly one, counter wrap from zero, a match inside a compare loop, and I/O sums that do and do not carry past 255.

// File: rtl/blkop_pkg.sv
package blkop_pkg;
    typedef enum logic [1:0] {
        GRP_COPY = 2'b00,
        GRP_CMP  = 2'b01,
        GRP_IN   = 2'b10,
        GRP_OUT  = 2'b11
    } grp_e;

    typedef struct packed {
        logic rep;
        grp_e grp;
        logic dec;
    } op_t;

    localparam int FB_S  = 7;
    localparam int FB_Z  = 6;
    localparam int FB_F5 = 5;
    localparam int FB_H  = 4;
    localparam int FB_F3 = 3;
    localparam int FB_PV = 2;
    localparam int FB_N  = 1;
    localparam int FB_C  = 0;
endpackage

// File: rtl/blkop_arith.sv
module blkop_arith
    import blkop_pkg::*;
#(
    parameter int BYTE_W = 8
) (
    input  op_t               op,
    input  logic [BYTE_W-1:0] acc,
    input  logic [BYTE_W-1:0] data,
    input  logic [2*BYTE_W-1:0] bc_in,
    input  logic [BYTE_W-1:0] l_reg,
    output logic [2*BYTE_W-1:0] bc_dec,
    output logic [BYTE_W-1:0] b_dec,
    output logic [BYTE_W-1:0] copy_sum,
    output logic [BYTE_W-1:0] cmp_diff,
    output logic              cmp_half,
    output logic [BYTE_W-1:0] cmp_adj,
    output logic [BYTE_W:0]   io_sum
);
    localparam int HALF_W = BYTE_W / 2;

    logic [BYTE_W-1:0] c_adj;
    logic [BYTE_W-1:0] io_addend;

    always_comb begin
        bc_dec   = bc_in - 1'b1;
        b_dec    = bc_in[2*BYTE_W-1:BYTE_W] - 1'b1;
        copy_sum = acc + data;
        cmp_diff = acc - data;
        cmp_half = acc[HALF_W-1:0] < data[HALF_W-1:0];
        cmp_adj  = cmp_diff - {{(BYTE_W-1){1'b0}}, cmp_half};
        c_adj    = op.dec ? (bc_in[BYTE_W-1:0] - 1'b1) : (bc_in[BYTE_W-1:0] + 1'b1);
        io_addend = (op.grp == GRP_OUT) ? l_reg : c_adj;
        io_sum   = {1'b0, data} + {1'b0, io_addend};
    end
endmodule

// File: rtl/blkop_flagmux.sv
module blkop_flagmux
    import blkop_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int COST_LOOP = 6,
    parameter int COST_COPY = 5,
    parameter int COST_CMP  = 4,
    parameter int COST_IO   = 5,
    parameter int NOP_W     = 3
) (
    input  op_t                 op,
    input  logic [BYTE_W-1:0]   acc,
    input  logic [BYTE_W-1:0]   data,
    input  logic [2*BYTE_W-1:0] bc_in,
    input  logic [BYTE_W-1:0]   flags_in,
    input  logic [2*BYTE_W-1:0] bc_dec,
    input  logic [BYTE_W-1:0]   b_dec,
    input  logic [BYTE_W-1:0]   copy_sum,
    input  logic [BYTE_W-1:0]   cmp_diff,
    input  logic                cmp_half,
    input  logic [BYTE_W-1:0]   cmp_adj,
    input  logic [BYTE_W:0]     io_sum,
    output logic [BYTE_W-1:0]   flags_nx,
    output logic [2*BYTE_W-1:0] bc_nx,
    output logic                rep_nx,
    output logic [NOP_W-1:0]    nops_nx
);
    logic bc_live;
    logic b_live;
    logic match;

    always_comb begin
        bc_live  = |bc_dec;
        b_live   = |b_dec;
        match    = (acc == data);
        flags_nx = flags_in;
        bc_nx    = bc_dec;
        rep_nx   = 1'b0;
        nops_nx  = NOP_W'(COST_COPY);
        unique case (op.grp)
            GRP_COPY: begin
                flags_nx[FB_H]  = 1'b0;
                flags_nx[FB_N]  = 1'b0;
                flags_nx[FB_PV] = bc_live;
                flags_nx[FB_F5] = copy_sum[1];
                flags_nx[FB_F3] = copy_sum[3];
                rep_nx  = op.rep & bc_live;
                nops_nx = NOP_W'(COST_COPY);
            end
            GRP_CMP: begin
                flags_nx[FB_S]  = cmp_diff[BYTE_W-1];
                flags_nx[FB_Z]  = match;
                flags_nx[FB_H]  = cmp_half;
                flags_nx[FB_N]  = 1'b1;
                flags_nx[FB_PV] = bc_live;
                flags_nx[FB_F5] = cmp_adj[1];
                flags_nx[FB_F3] = cmp_adj[3];
                rep_nx  = op.rep & bc_live & ~match;
                nops_nx = NOP_W'(COST_CMP);
            end
            GRP_IN, GRP_OUT: begin
                bc_nx           = {b_dec, bc_in[BYTE_W-1:0]};
                flags_nx[FB_S]  = b_dec[BYTE_W-1];
                flags_nx[FB_Z]  = ~b_live;
                flags_nx[FB_F5] = b_dec[5];
                flags_nx[FB_F3] = b_dec[3];
                flags_nx[FB_N]  = data[BYTE_W-1];
                flags_nx[FB_H]  = io_sum[BYTE_W];
                flags_nx[FB_C]  = io_sum[BYTE_W];
                flags_nx[FB_PV] = ~^({{(BYTE_W-3){1'b0}}, io_sum[2:0]} ^ b_dec);
                rep_nx  = op.rep & b_live;
                nops_nx = NOP_W'(COST_IO);
            end
            default: ;
        endcase
        if (rep_nx) begin
            nops_nx = NOP_W'(COST_LOOP);
        end
    end
endmodule

// File: rtl/blkop_flag_unit.sv
module blkop_flag_unit
    import blkop_pkg::*;
#(
    parameter int BYTE_W    = 8,
    parameter int COST_LOOP = 6,
    parameter int COST_COPY = 5,
    parameter int COST_CMP  = 4,
    parameter int COST_IO   = 5,
    parameter int NOP_W     = $clog2(COST_LOOP + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                valid_in,
    input  logic [3:0]          op,
    input  logic [BYTE_W-1:0]   acc,
    input  logic [BYTE_W-1:0]   data,
    input  logic [2*BYTE_W-1:0] bc_in,
    input  logic [BYTE_W-1:0]   l_reg,
    input  logic [BYTE_W-1:0]   flags_in,
    output logic                valid_out,
    output logic [BYTE_W-1:0]   flags_out,
    output logic [2*BYTE_W-1:0] bc_out,
    output logic                repeat_req,
    output logic [NOP_W-1:0]    nops
);
    typedef enum logic {ST_WAIT, ST_EMIT} state_e;

    state_e state_q, state_d;
    op_t    op_s;

    logic [2*BYTE_W-1:0] bc_dec;
    logic [BYTE_W-1:0]   b_dec, copy_sum, cmp_diff, cmp_adj, flags_nx;
    logic                cmp_half, rep_nx;
    logic [BYTE_W:0]     io_sum;
    logic [2*BYTE_W-1:0] bc_nx;
    logic [NOP_W-1:0]    nops_nx;

    assign op_s = op_t'(op);

    blkop_arith #(.BYTE_W(BYTE_W)) u_arith (
        .op(op_s), .acc(acc), .data(data), .bc_in(bc_in), .l_reg(l_reg),
        .bc_dec(bc_dec), .b_dec(b_dec), .copy_sum(copy_sum), .cmp_diff(cmp_diff),
        .cmp_half(cmp_half), .cmp_adj(cmp_adj), .io_sum(io_sum)
    );

    blkop_flagmux #(
        .BYTE_W(BYTE_W), .COST_LOOP(COST_LOOP), .COST_COPY(COST_COPY),
        .COST_CMP(COST_CMP), .COST_IO(COST_IO), .NOP_W(NOP_W)
    ) u_flagmux (
        .op(op_s), .acc(acc), .data(data), .bc_in(bc_in), .flags_in(flags_in),
        .bc_dec(bc_dec), .b_dec(b_dec), .copy_sum(copy_sum), .cmp_diff(cmp_diff),
        .cmp_half(cmp_half), .cmp_adj(cmp_adj), .io_sum(io_sum),
        .flags_nx(flags_nx), .bc_nx(bc_nx), .rep_nx(rep_nx), .nops_nx(nops_nx)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT: state_d = valid_in ? ST_EMIT : ST_WAIT;
            ST_EMIT: state_d = valid_in ? ST_EMIT : ST_WAIT;
            default: state_d = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_WAIT;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_out  <= '0;
            bc_out     <= '0;
            repeat_req <= 1'b0;
            nops       <= '0;
        end else if (valid_in) begin
            flags_out  <= flags_nx;
            bc_out     <= bc_nx;
            repeat_req <= rep_nx;
            nops       <= nops_nx;
        end
    end

    assign valid_out = (state_q == ST_EMIT);
endmodule

// File: rtl/blkop_flag_unit_chk.sv
module blkop_flag_unit_chk #(
    parameter int BYTE_W    = 8,
    parameter int COST_LOOP = 6,
    parameter int NOP_W     = 3
) (
    input logic                clk,
    input logic                rst_n,
    input logic                valid_in,
    input logic [3:0]          op,
    input logic                valid_out,
    input logic [BYTE_W-1:0]   flags_out,
    input logic                repeat_req,
    input logic [NOP_W-1:0]    nops
);
    assert_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
        valid_in |=> valid_out);
    assert_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_in |=> !valid_out);
    assert_copy_hn_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && op[2:1] == 2'b00) |=> (!flags_out[4] && !flags_out[1]));
    assert_cmp_n_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && op[2:1] == 2'b01) |=> flags_out[1]);
    assert_io_hc_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && op[2]) |=> (flags_out[4] == flags_out[0]));
    assert_single_no_rep_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_in && !op[3]) |=> !repeat_req);
    assert_loop_cost_R8: assert property (@(posedge clk) disable iff (!rst_n)
        valid_out |-> (repeat_req == (nops == NOP_W'(COST_LOOP))));
endmodule

bind blkop_flag_unit blkop_flag_unit_chk #(
    .BYTE_W(BYTE_W), .COST_LOOP(COST_LOOP), .NOP_W(NOP_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .op(op),
    .valid_out(valid_out), .flags_out(flags_out),
    .repeat_req(repeat_req), .nops(nops)
);

// File: tb/blkop_flag_unit_tb.sv
module blkop_flag_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_in = 1'b0;
    logic [3:0]  op = '0;
    logic [7:0]  acc = '0, data = '0, l_reg = '0, flags_in = '0;
    logic [15:0] bc_in = '0;
    logic        valid_out, repeat_req;
    logic [7:0]  flags_out;
    logic [15:0] bc_out;
    logic [2:0]  nops;
    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    blkop_flag_unit u_dut (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .op(op), .acc(acc),
        .data(data), .bc_in(bc_in), .l_reg(l_reg), .flags_in(flags_in),
        .valid_out(valid_out), .flags_out(flags_out), .bc_out(bc_out),
        .repeat_req(repeat_req), .nops(nops)
    );

    typedef struct packed {
        logic [3:0]  op;
        logic [7:0]  a;
        logic [7:0]  d;
        logic [15:0] bc;
        logic [7:0]  l;
        logic [7:0]  f;
    } vec_t;

    localparam vec_t VECS [16] = '{
        '{4'h0, 8'h12, 8'h22, 16'h0001, 8'h00, 8'hC1},
        '{4'h1, 8'h7F, 8'h01, 16'h0100, 8'h00, 8'h00},
        '{4'h2, 8'h33, 8'h35, 16'h0002, 8'h00, 8'h00},
        '{4'h3, 8'h80, 8'h01, 16'h0001, 8'h00, 8'hFF},
        '{4'h4, 8'h00, 8'h9C, 16'h0203, 8'h00, 8'h00},
        '{4'h5, 8'h00, 8'h10, 16'h01FE, 8'h00, 8'h01},
        '{4'h6, 8'h00, 8'hF0, 16'h0310, 8'h20, 8'h00},
        '{4'h7, 8'h00, 8'h7F, 16'h0000, 8'h81, 8'hFF},
        '{4'h8, 8'h01, 8'h09, 16'h0005, 8'h00, 8'h00},
        '{4'h9, 8'hAA, 8'h55, 16'h0000, 8'h00, 8'h41},
        '{4'hA, 8'h40, 8'h40, 16'h0003, 8'h00, 8'h01},
        '{4'hB, 8'h10, 8'h20, 16'h0002, 8'h00, 8'h00},
        '{4'hC, 8'h00, 8'h80, 16'h01FF, 8'h00, 8'h00},
        '{4'hD, 8'h00, 8'hC8, 16'h0540, 8'h00, 8'h00},
        '{4'hE, 8'h00, 8'h08, 16'h0201, 8'hFC, 8'h28},
        '{4'hF, 8'h00, 8'h01, 16'h0101, 8'h02, 8'h00}
    };

    // Reference model written from R3..R9
    function automatic logic [27:0] model(vec_t v);
        logic [7:0]  f = v.f;
        logic [15:0] bc;
        logic        rp;
        logic [2:0]  cost;
        logic [7:0]  s8, b;
        logic [8:0]  k;
        logic        h;
        case (v.op[2:1])
            2'b00: begin
                bc = v.bc - 16'd1; s8 = v.a + v.d;
                f[4] = 0; f[1] = 0; f[2] = (bc != 0); f[5] = s8[1]; f[3] = s8[3];
                rp = v.op[3] && bc != 0; cost = 5;
            end
            2'b01: begin
                bc = v.bc - 16'd1; s8 = v.a - v.d; h = (v.a[3:0] < v.d[3:0]);
                f[7] = s8[7]; f[6] = (v.a == v.d); f[4] = h; f[1] = 1; f[2] = (bc != 0);
                s8 = s8 - {7'd0, h}; f[5] = s8[1]; f[3] = s8[3];
                rp = v.op[3] && bc != 0 && v.a != v.d; cost = 4;
            end
            default: begin
                b = v.bc[15:8] - 8'd1; bc = {b, v.bc[7:0]};
                if (v.op[2:1] == 2'b11) k = {1'b0, v.d} + {1'b0, v.l};
                else if (v.op[0]) k = {1'b0, v.d} + {1'b0, 8'(v.bc[7:0] - 8'd1)};
                else k = {1'b0, v.d} + {1'b0, 8'(v.bc[7:0] + 8'd1)};
                f[7] = b[7]; f[6] = (b == 0); f[5] = b[5]; f[3] = b[3]; f[1] = v.d[7];
                f[4] = k[8]; f[0] = k[8];
                f[2] = ($countones({5'd0, k[2:0]} ^ b) % 2) == 0;
                rp = v.op[3] && b != 0; cost = 5;
            end
        endcase
        if (rp) cost = 6;
        return {f, bc, rp, cost};
    endfunction

    task automatic step(input vec_t v);
        @(negedge clk);
        op = v.op; acc = v.a; data = v.d; bc_in = v.bc; l_reg = v.l; flags_in = v.f;
        valid_in = 1'b1;
        @(negedge clk);
        valid_in = 1'b0;
    endtask

    task automatic check(input string req, input logic [27:0] act, input logic [27:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [27:0] got();
        return {flags_out, bc_out, repeat_req, nops};
    endfunction

    initial begin
        #2000000;
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R2 reset state
        check("R2 reset", {got(), 3'b0, valid_out}, 31'd0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 16; i++) begin
            step(VECS[i]);
            check("R1/R2 valid strobe", {27'd0, valid_out}, 28'd1);
            check("R3-table R4 R5 R6 R7 R8 vector", got(), model(VECS[i]));
        end
        // R2 hold: output drops and value is held
        @(negedge clk);
        check("R2 drop", {27'd0, valid_out}, 28'd0);
        check("R2 hold", got(), model(VECS[15]));
        // R3 single copy, last element
        step('{4'h0, 8'h12, 8'h22, 16'h0001, 8'h00, 8'hC1});
        check("R3 ldi last", got(), {8'hC1, 16'h0000, 1'b0, 3'd5});
        // R3 R7 R8 repeating copy
        step('{4'h8, 8'h01, 8'h09, 16'h0005, 8'h00, 8'h00});
        check("R3 R7 R8 ldir loop", got(), {8'h2C, 16'h0004, 1'b1, 3'd6});
        // R4 R7 compare match stops loop
        step('{4'hA, 8'h40, 8'h40, 16'h0003, 8'h00, 8'h01});
        check("R4 R7 cpir match", got(), {8'h47, 16'h0002, 1'b0, 3'd4});
        // R5 R6 input with B reaching zero
        step('{4'hC, 8'h00, 8'h80, 16'h01FF, 8'h00, 8'h00});
        check("R5 R6 inir last", got(), {8'h46, 16'h00FF, 1'b0, 3'd5});
        // R6 output with carry out
        step('{4'h6, 8'h00, 8'hF0, 16'h0310, 8'h20, 8'h00});
        check("R6 outi carry", got(), {8'h13, 16'h0210, 1'b0, 3'd5});
        // R9 copy wrap from zero
        step('{4'h8, 8'h00, 8'h00, 16'h0000, 8'h00, 8'h00});
        check("R9 ldir wrap", got(), {8'h04, 16'hFFFF, 1'b1, 3'd6});
        // R9 I/O wrap from B=0
        step('{4'h6, 8'h00, 8'h00, 16'h0000, 8'h00, 8'h00});
        check("R9 outi wrap", {flags_out[7], bc_out}, {1'b1, 16'hFF00});
        // R2 back-to-back strobes
        @(negedge clk);
        op = 4'h0; acc = 8'h00; data = 8'h00; bc_in = 16'h0002; flags_in = 8'h00; valid_in = 1'b1;
        @(negedge clk);
        bc_in = 16'h0003;
        @(negedge clk);
        valid_in = 1'b0;
        check("R2 back-to-back", {11'd0, valid_out, bc_out}, {11'd0, 1'b1, 16'h0002});
        @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule